// File: doc/BRIEF.md
# Probe-mode run controller

This block moves a processor core between normal execution and a halted debug state (probe mode). It watches an asynchronous active-low debug-request pin, a one-bit probe-mode data register written from the JTAG side, and event strobes from the core: single step, hardware breakpoint, software breakpoint and shutdown. On any accepted entry it raises a halt request to the core and pulls the active-low probe-ready pin low. It then waits for the core to report that its register state has been saved. An exit comes from a zero written to the probe-mode data register, or from reset.

The entry paths are a falling edge on the request pin, a redirect armed by a one written to the data register, and a shutdown when shutdown break is enabled. A request pin held low while reset is released also causes an entry, so firmware can be debugged from its first instruction. The pin is only sampled while the test clock is reported running. A 32-bit status word reports the shutdown cause, the shutdown enable, software-breakpoint support, the redirect arm and the saved state.

Top module: `probe_run_ctrl`

## Requirements
- R1: While `rst_n` is low and at the first edge after its release with the request pin high, `prdy_n` is 1, `halt_req` is 0, the redirect arm (status bit 3) is 0, and status reads 0x10 plus bit 5 from `shut_brk_en`.
- R2: When `dbg_req_n` falls while running and the test clock is running, `prdy_n` goes to 0 and `halt_req` to 1 after the third rising clock edge following the fall, through a two-flop synchroniser and an edge detector.
- R3: A `tap_wr` with `tap_wdata`=1 sets status bit 3. While bit 3 is set and the core is running, a pulse on `ev_step`, `ev_hwbp` or `ev_swbp` enters probe mode at the next edge. With bit 3 clear these strobes have no effect.
- R4: From the edge after any entry is accepted until an exit, `prdy_n` is 0 and `halt_req` is 1.
- R5: A `tap_wr` with `tap_wdata`=0 while in probe mode returns `prdy_n` to 1 and `halt_req` to 0 at the next edge, and it clears status bit 3.
- R6: Asserting `rst_n` low while in probe mode forces an exit: `prdy_n` is 1, `halt_req` is 0, and status bits 2, 3 and 6 are 0.
- R7: While `tck_running` is 0, a pulse on `dbg_req_n` is not captured and causes no entry.
- R8: If `dbg_req_n` is held low across the release of `rst_n`, probe mode is entered at the first rising edge after the release.
- R9: `ev_shutdown` while running with `shut_brk_en`=1 enters probe mode and sets status bit 6. With `shut_brk_en`=0 it has no effect. Bit 6 is 0 whenever the core is not in probe mode.
- R10: Status bit 5 equals `shut_brk_en`, bit 4 reads 1, and bits 31:7 and 1:0 read 0.
- R11: Status bit 2 goes to 1 at the edge after `save_done` is seen in probe mode and returns to 0 on exit.
- R12: While in probe mode, further entry causes (pin fall, redirect event, enabled shutdown) are ignored: bit 6 stays 0 and bit 2 keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset; forces exit from probe mode |
| tck_running | input | 1 | High while the test clock runs; gates capture of the request pin |
| dbg_req_n | input | 1 | Asynchronous active-low debug request pin |
| tap_wr | input | 1 | Write strobe of the probe-mode data register |
| tap_wdata | input | 1 | Data written: 1 arms redirect, 0 exits and disarms |
| ev_step | input | 1 | Single-step completion strobe |
| ev_hwbp | input | 1 | Hardware breakpoint strobe |
| ev_swbp | input | 1 | Software breakpoint strobe |
| ev_shutdown | input | 1 | Shutdown event strobe |
| shut_brk_en | input | 1 | Shutdown break enable control bit |
| save_done | input | 1 | Core acknowledge that register state is saved |
| prdy_n | output | 1 | Active-low probe-ready; low while in probe mode |
| halt_req | output | 1 | Halt request to the core |
| status | output | 32 | Status word |

## Verification
The bench goes after the timing of the request pin. A design with a missing or extra synchroniser stage would enter one edge early or late. A design that gates the pin wrongly would take a pulse while the test clock is stopped, and one whose edge detector resets to the wrong level would miss the break on a pin held low across reset. It arms the redirect and fires each of the three debug events in turn, and it fires the same events unarmed, so a decoder that ignores the arm would halt the core. Shutdown is driven with the enable set and clear, and again while already halted. A design that lets a second entry through would set the shutdown-cause bit or drop the saved bit. A reset applied mid-probe must clear the arm and the saved state.

// File: rtl/prm_pkg.sv
package prm_pkg;

    typedef enum logic [1:0] {
        PRM_RUN     = 2'd0,
        PRM_HALTING = 2'd1,
        PRM_SAVED   = 2'd2
    } prm_state_e;

    // status word bit positions
    localparam int unsigned ST_SAVED_BIT  = 2;
    localparam int unsigned ST_REDIR_BIT  = 3;
    localparam int unsigned ST_SWBP_BIT   = 4;
    localparam int unsigned ST_SHEN_BIT   = 5;
    localparam int unsigned ST_SHOCC_BIT  = 6;
    localparam int unsigned ST_USED_TOP   = 6;

    typedef struct packed {
        prm_state_e st;
        logic       redir;
        logic       shut_occ;
    } prm_ctl_t;

endpackage

// File: rtl/prm_req_sync.sv
module prm_req_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tck_running,
    input  logic req_n_async,
    output logic req_fall
);
    localparam int unsigned LAST = STAGES - 1;

    logic [STAGES-1:0] chain_q;
    logic              prev_d;
    logic              prev_q;

    // synchroniser chain, advanced only while the test clock runs
    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (tck_running) begin
                    chain_q <= req_n_async;
                end
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (tck_running) begin
                    chain_q <= {chain_q[STAGES-2:0], req_n_async};
                end
            end
        end
    endgenerate

    always_comb begin
        prev_d = chain_q[LAST];
    end

    // previous value resets to the idle (high) level so a pin held low
    // across reset release shows as a fall on the first edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b1;
        end else begin
            prev_q <= prev_d;
        end
    end

    assign req_fall = prev_q & ~chain_q[LAST];

endmodule

// File: rtl/prm_entry_dec.sv
module prm_entry_dec (
    input  logic req_fall,
    input  logic redir_q,
    input  logic ev_step,
    input  logic ev_hwbp,
    input  logic ev_swbp,
    input  logic ev_shutdown,
    input  logic shut_brk_en,
    output logic entry_req,
    output logic entry_shut
);
    logic redirect_hit;
    logic shut_hit;

    always_comb begin
        redirect_hit = redir_q & (ev_step | ev_hwbp | ev_swbp);
        shut_hit     = shut_brk_en & ev_shutdown;
        entry_req    = req_fall | redirect_hit | shut_hit;
        entry_shut   = shut_hit;
    end

endmodule

// File: rtl/prm_fsm.sv
module prm_fsm
    import prm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       entry_req,
    input  logic       entry_shut,
    input  logic       tap_wr,
    input  logic       tap_wdata,
    input  logic       save_done,
    output prm_state_e state,
    output logic       redir,
    output logic       shut_occ
);
    prm_ctl_t ctl_d;
    prm_ctl_t ctl_q;
    logic     exit_cmd;

    always_comb begin
        exit_cmd = tap_wr & ~tap_wdata;
        ctl_d    = ctl_q;

        if (tap_wr) begin
            ctl_d.redir = tap_wdata;
        end

        unique case (ctl_q.st)
            PRM_RUN: begin
                if (entry_req) begin
                    ctl_d.st       = PRM_HALTING;
                    ctl_d.shut_occ = entry_shut;
                end
            end
            PRM_HALTING: begin
                if (exit_cmd) begin
                    ctl_d.st       = PRM_RUN;
                    ctl_d.shut_occ = 1'b0;
                end else if (save_done) begin
                    ctl_d.st = PRM_SAVED;
                end
            end
            PRM_SAVED: begin
                if (exit_cmd) begin
                    ctl_d.st       = PRM_RUN;
                    ctl_d.shut_occ = 1'b0;
                end
            end
            default: begin
                ctl_d.st       = PRM_RUN;
                ctl_d.shut_occ = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: PRM_RUN, redir: 1'b0, shut_occ: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign state    = ctl_q.st;
    assign redir    = ctl_q.redir;
    assign shut_occ = ctl_q.shut_occ;

endmodule

// File: rtl/prm_status.sv
module prm_status
    import prm_pkg::*;
#(
    parameter int unsigned STATUS_W = 32
) (
    input  logic                shut_occ,
    input  logic                shut_brk_en,
    input  logic                redir,
    input  logic                saved,
    output logic [STATUS_W-1:0] status
);
    always_comb begin
        status               = '0;
        status[ST_SAVED_BIT] = saved;
        status[ST_REDIR_BIT] = redir;
        status[ST_SWBP_BIT]  = 1'b1;
        status[ST_SHEN_BIT]  = shut_brk_en;
        status[ST_SHOCC_BIT] = shut_occ;
    end

endmodule

// File: rtl/probe_run_ctrl.sv
module probe_run_ctrl
    import prm_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned STATUS_W    = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tck_running,
    input  logic                dbg_req_n,
    input  logic                tap_wr,
    input  logic                tap_wdata,
    input  logic                ev_step,
    input  logic                ev_hwbp,
    input  logic                ev_swbp,
    input  logic                ev_shutdown,
    input  logic                shut_brk_en,
    input  logic                save_done,
    output logic                prdy_n,
    output logic                halt_req,
    output logic [STATUS_W-1:0] status
);
    logic       req_fall;
    logic       entry_req;
    logic       entry_shut;
    prm_state_e state;
    logic       redir;
    logic       shut_occ;
    logic       in_probe;

    prm_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk         (clk),
        .rst_n       (rst_n),
        .tck_running (tck_running),
        .req_n_async (dbg_req_n),
        .req_fall    (req_fall)
    );

    prm_entry_dec u_dec (
        .req_fall    (req_fall),
        .redir_q     (redir),
        .ev_step     (ev_step),
        .ev_hwbp     (ev_hwbp),
        .ev_swbp     (ev_swbp),
        .ev_shutdown (ev_shutdown),
        .shut_brk_en (shut_brk_en),
        .entry_req   (entry_req),
        .entry_shut  (entry_shut)
    );

    prm_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .entry_req  (entry_req),
        .entry_shut (entry_shut),
        .tap_wr     (tap_wr),
        .tap_wdata  (tap_wdata),
        .save_done  (save_done),
        .state      (state),
        .redir      (redir),
        .shut_occ   (shut_occ)
    );

    assign in_probe = (state != PRM_RUN);
    assign prdy_n   = ~in_probe;
    assign halt_req = in_probe;

    prm_status #(.STATUS_W(STATUS_W)) u_status (
        .shut_occ    (shut_occ),
        .shut_brk_en (shut_brk_en),
        .redir       (redir),
        .saved       (state == PRM_SAVED),
        .status      (status)
    );

endmodule

// File: rtl/prm_chk.sv
module prm_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        tap_wr,
    input logic        tap_wdata,
    input logic        ev_step,
    input logic        ev_hwbp,
    input logic        ev_swbp,
    input logic        ev_shutdown,
    input logic        shut_brk_en,
    input logic        save_done,
    input logic        prdy_n,
    input logic [31:0] status
);
    // R3
    redirect_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prdy_n && status[3] && (ev_step || ev_hwbp || ev_swbp)) |=> !prdy_n);

    // R5
    exit_on_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!prdy_n && tap_wr && !tap_wdata) |=> prdy_n);

    // R5
    disarm_on_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tap_wr && !tap_wdata) |=> !status[3]);

    // R12
    stay_in_probe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!prdy_n && !(tap_wr && !tap_wdata)) |=> !prdy_n);

    // R9
    shutdown_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prdy_n && shut_brk_en && ev_shutdown) |=> (!prdy_n && status[6]));

    // R9
    shut_cause_only_in_probe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prdy_n |-> !status[6]);

    // R11
    saved_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!prdy_n && save_done && !(tap_wr && !tap_wdata)) |=> status[2]);

    // R11
    saved_only_in_probe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prdy_n |-> !status[2]);

endmodule

bind probe_run_ctrl prm_chk u_prm_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tap_wr      (tap_wr),
    .tap_wdata   (tap_wdata),
    .ev_step     (ev_step),
    .ev_hwbp     (ev_hwbp),
    .ev_swbp     (ev_swbp),
    .ev_shutdown (ev_shutdown),
    .shut_brk_en (shut_brk_en),
    .save_done   (save_done),
    .prdy_n      (prdy_n),
    .status      (status)
);

// File: tb/tb_probe_run_ctrl.sv
`timescale 1ns/1ps
module tb_probe_run_ctrl;
    logic        clk = 1'b0;
    logic        rst_n, tck_running, dbg_req_n, tap_wr, tap_wdata;
    logic        ev_step, ev_hwbp, ev_swbp, ev_shutdown, shut_brk_en, save_done;
    logic        prdy_n, halt_req;
    logic [31:0] status;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        string       tag;
        logic        prdy;
        logic        halt;
        logic [31:0] st;
    } exp_t;
    exp_t exp_q[$];

    always #5 clk = ~clk;

    probe_run_ctrl dut (
        .clk(clk), .rst_n(rst_n), .tck_running(tck_running), .dbg_req_n(dbg_req_n),
        .tap_wr(tap_wr), .tap_wdata(tap_wdata), .ev_step(ev_step), .ev_hwbp(ev_hwbp),
        .ev_swbp(ev_swbp), .ev_shutdown(ev_shutdown), .shut_brk_en(shut_brk_en),
        .save_done(save_done), .prdy_n(prdy_n), .halt_req(halt_req), .status(status)
    );

    function automatic logic [31:0] stv(logic so, logic en, logic rd, logic sv);
        return 32'h10 | ({31'd0, so} << 6) | ({31'd0, en} << 5) |
               ({31'd0, rd} << 3) | ({31'd0, sv} << 2);
    endfunction

    // expectation for the outputs after the next rising edge
    task automatic push(string tag, logic p, logic h, logic [31:0] s);
        exp_t e;
        e.tag = tag; e.prdy = p; e.halt = h; e.st = s;
        exp_q.push_back(e);
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // monitor: compares between the rising edge and the next falling edge
    initial begin
        forever begin
            @(posedge clk);
            #3;
            while (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                checks++;
                if (prdy_n !== e.prdy || halt_req !== e.halt || status !== e.st) begin
                    failures++;
                    $display("FAIL %s: prdy_n=%b halt_req=%b status=%h expected prdy_n=%b halt_req=%b status=%h",
                             e.tag, prdy_n, halt_req, status, e.prdy, e.halt, e.st);
                end
            end
        end
    end

    task automatic do_save(string tag, logic so, logic en, logic rd);
        save_done = 1'b1;
        push(tag, 1'b0, 1'b1, stv(so, en, rd, 1'b1));
        tick();
        save_done = 1'b0;
    endtask

    task automatic do_exit(string tag, logic en);
        tap_wr = 1'b1; tap_wdata = 1'b0;
        push(tag, 1'b1, 1'b0, stv(1'b0, en, 1'b0, 1'b0));
        tick();
        tap_wr = 1'b0;
    endtask

    task automatic do_arm(string tag, logic en);
        tap_wr = 1'b1; tap_wdata = 1'b1;
        push(tag, 1'b1, 1'b0, stv(1'b0, en, 1'b1, 1'b0));
        tick();
        tap_wr = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0; tck_running = 1'b1; dbg_req_n = 1'b1; tap_wr = 1'b0; tap_wdata = 1'b0;
        ev_step = 1'b0; ev_hwbp = 1'b0; ev_swbp = 1'b0; ev_shutdown = 1'b0;
        shut_brk_en = 1'b0; save_done = 1'b0;
        tick();
        // R1 reset state
        push("R1 in reset", 1'b1, 1'b0, stv(0, 0, 0, 0));
        tick();
        rst_n = 1'b1;
        push("R1 after release", 1'b1, 1'b0, stv(0, 0, 0, 0));
        tick();

        // R2 pin fall: entry after the third edge
        dbg_req_n = 1'b0;
        push("R2 edge1", 1'b1, 1'b0, stv(0, 0, 0, 0));
        tick();
        push("R2 edge2", 1'b1, 1'b0, stv(0, 0, 0, 0));
        tick();
        dbg_req_n = 1'b1;
        push("R2 R4 edge3 entry", 1'b0, 1'b1, stv(0, 0, 0, 0));
        tick();
        push("R4 held", 1'b0, 1'b1, stv(0, 0, 0, 0));
        tick();
        do_save("R11 saved", 0, 0, 0);

        // R12 entries ignored in probe, R10 enable mirror
        shut_brk_en = 1'b1;
        ev_shutdown = 1'b1; ev_swbp = 1'b1; dbg_req_n = 1'b0;
        push("R12 R10 ignored", 1'b0, 1'b1, stv(0, 1, 0, 1));
        tick();
        ev_shutdown = 1'b0; ev_swbp = 1'b0;
        push("R12 still saved", 1'b0, 1'b1, stv(0, 1, 0, 1));
        tick();
        dbg_req_n = 1'b1;
        for (int i = 0; i < 3; i++) begin
            push("R12 pin ignored", 1'b0, 1'b1, stv(0, 1, 0, 1));
            tick();
        end
        do_exit("R5 R11 exit", 1'b1);
        shut_brk_en = 1'b0;
        push("R10 enable low", 1'b1, 1'b0, stv(0, 0, 0, 0));
        tick();

        // R3 unarmed events do nothing
        ev_step = 1'b1; ev_hwbp = 1'b1; ev_swbp = 1'b1;
        push("R3 unarmed", 1'b1, 1'b0, stv(0, 0, 0, 0));
        tick();
        ev_step = 1'b0; ev_hwbp = 1'b0; ev_swbp = 1'b0;
        push("R3 unarmed after", 1'b1, 1'b0, stv(0, 0, 0, 0));
        tick();

        // R3 armed redirect for each event kind
        for (int k = 0; k < 3; k++) begin
            do_arm("R3 arm", 1'b0);
            push("R3 armed idle", 1'b1, 1'b0, stv(0, 0, 1, 0));
            tick();
            ev_step = (k == 0); ev_hwbp = (k == 1); ev_swbp = (k == 2);
            push("R3 R4 redirect entry", 1'b0, 1'b1, stv(0, 0, 1, 0));
            tick();
            ev_step = 1'b0; ev_hwbp = 1'b0; ev_swbp = 1'b0;
            do_save("R11 redirect saved", 0, 0, 1);
            do_exit("R5 redirect exit", 1'b0);
        end

        // R9 shutdown without enable ignored
        ev_shutdown = 1'b1;
        push("R9 disabled", 1'b1, 1'b0, stv(0, 0, 0, 0));
        tick();
        ev_shutdown = 1'b0;
        push("R9 disabled after", 1'b1, 1'b0, stv(0, 0, 0, 0));
        tick();
        // R9 shutdown break
        shut_brk_en = 1'b1;
        ev_shutdown = 1'b1;
        push("R9 shutdown entry", 1'b0, 1'b1, stv(1, 1, 0, 0));
        tick();
        ev_shutdown = 1'b0;
        do_save("R9 R11 shutdown saved", 1, 1, 0);
        do_exit("R9 cause cleared", 1'b1);
        shut_brk_en = 1'b0;

        // R6 reset during probe
        do_arm("R6 arm", 1'b0);
        ev_hwbp = 1'b1;
        push("R6 entry", 1'b0, 1'b1, stv(0, 0, 1, 0));
        tick();
        ev_hwbp = 1'b0;
        do_save("R6 saved", 0, 0, 1);
        rst_n = 1'b0;
        push("R6 reset exit", 1'b1, 1'b0, stv(0, 0, 0, 0));
        tick();
        rst_n = 1'b1;
        push("R6 after reset", 1'b1, 1'b0, stv(0, 0, 0, 0));
        tick();

        // R7 pin pulse while test clock stopped
        tck_running = 1'b0;
        tick();
        dbg_req_n = 1'b0;
        for (int i = 0; i < 4; i++) begin
            push("R7 stopped", 1'b1, 1'b0, stv(0, 0, 0, 0));
            tick();
        end
        dbg_req_n = 1'b1;
        tick();
        tck_running = 1'b1;
        for (int i = 0; i < 4; i++) begin
            push("R7 resumed", 1'b1, 1'b0, stv(0, 0, 0, 0));
            tick();
        end

        // R8 request held across reset release
        rst_n = 1'b0;
        dbg_req_n = 1'b0;
        for (int i = 0; i < 4; i++) begin
            push("R8 in reset", 1'b1, 1'b0, stv(0, 0, 0, 0));
            tick();
        end
        rst_n = 1'b1;
        push("R8 reset break", 1'b0, 1'b1, stv(0, 0, 0, 0));
        tick();
        dbg_req_n = 1'b1;
        do_save("R8 saved", 0, 0, 0);
        do_exit("R8 exit", 1'b0);

        tick();
        tick();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule